// File: doc/BRIEF.md
# 8-bit Waveform Timer with Clear-on-Compare and Single-Slope PWM

This block is an 8-bit up-counter fed by its own clock divider. It compares the count against a programmable compare value. It can run in three ways. In clear-on-compare mode the count returns to zero after it meets the compare value, and the output pin can toggle, clear or set on every match. In single-slope PWM mode the count climbs from zero to a top value and restarts; the top value is either fixed at all-ones or taken from the compare value. Every other mode code gives a plain free-running wrap-around counter.

Two sticky event flags record compare matches and counter roll-over, and a one-hot clear input clears them. Software-side logic writes the compare value through a single-cycle write strobe. In clear-on-compare mode a write takes effect at once. In PWM mode the write is held in a shadow register until the period ends. A divider select of zero freezes the count.

Top module: `tmr8_timer`

## Requirements
- R1: While rst_n is low, cnt_o, wave_o, match_flag_o and ovf_flag_o are 0, and the active and shadow compare values are 0.
- R2: A free-running 10-bit divider produces a count tick. clk_sel 1..7 gives one tick every 1, 8, 32, 64, 128, 256 or 1024 clocks. clk_sel 0 gives no tick, so the count holds. The counter changes only on a tick.
- R3: With mode_sel = 2 (clear-on-compare), a tick where cnt_o equals the active compare value loads 0; any other tick increments.
- R4: With mode_sel = 2, a write reaches the active compare value in the next cycle. If it is below the current count, the counter climbs to 0xFF and wraps to 0x00 before it can match.
- R5: With mode_sel = 2, a match tick changes wave_o according to out_mode: 1 toggles it, 2 drives 0, 3 drives 1, 0 leaves it unchanged. A compare value of 0 with clk_sel = 1 toggles wave_o every clock.
- R6: With mode_sel = 3 the count wraps at 0xFF. With mode_sel = 7 it returns to 0 on the tick after it equals the active compare value.
- R7: In PWM modes (3 or 7) with out_mode = 2, the tick that leaves the top value sets wave_o and a match tick clears it. With out_mode = 3 the same two ticks clear and set wave_o instead. If both happen on one tick, the action at the top wins. With out_mode 0 or 1, wave_o holds.
- R8: In PWM modes a write goes only to the shadow value. The shadow is copied to the active compare value on a tick where the count is at the top value, and the copy uses the shadow as it was before any write in that same cycle.
- R9: match_flag_o is set after any tick where cnt_o equals the active compare value. ovf_flag_o is set after any tick where cnt_o is 0xFF.
- R10: flag_clr bit 0 clears match_flag_o and bit 1 clears ovf_flag_o. If a set event and a clear happen in the same cycle, the flag is set.
- R11: With mode_sel 0, 1, 4, 5 or 6 the count wraps from 0xFF to 0x00, writes act at once, and wave_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| mode_sel | input | 3 | Operating mode code (2 clear-on-compare, 3 PWM top 0xFF, 7 PWM top from compare) |
| clk_sel | input | 3 | Divider select: 0 stop, 1..7 divide by 1, 8, 32, 64, 128, 256, 1024 |
| out_mode | input | 2 | Output action on compare and top events |
| cmp_wr_en | input | 1 | One-cycle strobe writing the compare value |
| cmp_wr_data | input | 8 | Compare value to write |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 match flag, bit 1 overflow flag |
| cnt_o | output | 8 | Current count |
| wave_o | output | 1 | Waveform output |
| match_flag_o | output | 1 | Sticky compare-match flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The properties assume that mode_sel, clk_sel and out_mode come from registers that change only between clock edges. They also assume that a mode change is a legal operation at any cycle, since every property judges one edge at a time from the values sampled just before it. The bench drives every input on the falling edge. It changes mode and divider only at segment boundaries, and it picks writes and flag clears at random inside a segment. It also biases compare values low in clear-on-compare segments so that matches, missed matches and wraps all occur often.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    K_PLAIN   = 2'd0,
    K_CTC     = 2'd1,
    K_PWM_FIX = 2'd2,
    K_PWM_VAR = 2'd3
  } kind_e;

  localparam logic [1:0] OM_OFF  = 2'd0;
  localparam logic [1:0] OM_TOG  = 2'd1;
  localparam logic [1:0] OM_LOW  = 2'd2;
  localparam logic [1:0] OM_HIGH = 2'd3;

  function automatic kind_e decode_mode(input logic [2:0] m);
    case (m)
      3'd2:    return K_CTC;
      3'd3:    return K_PWM_FIX;
      3'd7:    return K_PWM_VAR;
      default: return K_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);

  localparam int NSEL = 8;

  logic [DIV_W-1:0] div_q, div_d;
  logic [NSEL-1:0]  tick_vec;

  function automatic int tap_width(input int s);
    case (s)
      2:       return 3;
      3:       return 5;
      4:       return 6;
      5:       return 7;
      6:       return 8;
      7:       return DIV_W;
      default: return 0;
    endcase
  endfunction

  assign tick_vec[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 1; gi < NSEL; gi++) begin : g_tap
      localparam logic [DIV_W-1:0] MASK = {DIV_W{1'b1}} >> (DIV_W - tap_width(gi));
      assign tick_vec[gi] = ((div_q & MASK) == MASK);
    end
  endgenerate

  always_comb begin
    div_d = div_q + DIV_W'(1);
    tick  = tick_vec[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  kind_e            kind,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] act_q,
  output logic             ev_match,
  output logic             ev_top,
  output logic             ev_ovf
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d, act_d, shd_q, shd_d, top;
  logic             pwm;

  always_comb begin
    pwm      = (kind == K_PWM_FIX) || (kind == K_PWM_VAR);
    top      = ((kind == K_CTC) || (kind == K_PWM_VAR)) ? act_q : MAXV;
    ev_match = tick && (cnt_q == act_q);
    ev_top   = tick && (cnt_q == top);
    ev_ovf   = tick && (cnt_q == MAXV);

    cnt_d = cnt_q;
    if (tick) cnt_d = ev_top ? '0 : cnt_q + CNT_W'(1);

    shd_d = wr_en ? wr_data : shd_q;
    act_d = act_q;
    if (pwm) begin
      if (ev_top) act_d = shd_q;
    end else if (wr_en) begin
      act_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      shd_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      shd_q <= shd_d;
    end
  end

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  kind_e      kind,
  input  logic [1:0] om,
  input  logic       ev_match,
  input  logic       ev_top,
  output logic       wave_q
);

  logic wave_d;

  always_comb begin
    wave_d = wave_q;
    case (kind)
      K_CTC: begin
        if (ev_match) begin
          case (om)
            OM_TOG:  wave_d = !wave_q;
            OM_LOW:  wave_d = 1'b0;
            OM_HIGH: wave_d = 1'b1;
            default: wave_d = wave_q;
          endcase
        end
      end
      K_PWM_FIX, K_PWM_VAR: begin
        if (om == OM_LOW) begin
          if (ev_top)        wave_d = 1'b1;
          else if (ev_match) wave_d = 1'b0;
        end else if (om == OM_HIGH) begin
          if (ev_top)        wave_d = 1'b0;
          else if (ev_match) wave_d = 1'b1;
        end
      end
      default: wave_d = wave_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_ev,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flag_q
);

  logic [NFLAG-1:0] flag_d;

  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_flag
      always_comb flag_d[gi] = set_ev[gi] | (flag_q[gi] & ~clr[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel,
  input  logic [2:0]       clk_sel,
  input  logic [1:0]       out_mode,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic [1:0]       flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_o,
  output logic             match_flag_o,
  output logic             ovf_flag_o
);

  localparam int NFLAG = 2;

  kind_e            kind;
  logic             tick;
  logic [CNT_W-1:0] cmp_act;
  logic             ev_match, ev_top, ev_ovf;
  logic [NFLAG-1:0] flags;

  assign kind = decode_mode(mode_sel);

  tmr8_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (clk_sel),
    .tick  (tick)
  );

  tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .kind     (kind),
    .wr_en    (cmp_wr_en),
    .wr_data  (cmp_wr_data),
    .cnt_q    (cnt_o),
    .act_q    (cmp_act),
    .ev_match (ev_match),
    .ev_top   (ev_top),
    .ev_ovf   (ev_ovf)
  );

  tmr8_wave u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .om       (out_mode),
    .ev_match (ev_match),
    .ev_top   (ev_top),
    .wave_q   (wave_o)
  );

  tmr8_flags #(.NFLAG(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev ({ev_ovf, ev_match}),
    .clr    (flag_clr),
    .flag_q (flags)
  );

  assign match_flag_o = flags[0];
  assign ovf_flag_o   = flags[1];

endmodule

// File: rtl/tmr8_timer_chk.sv
module tmr8_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_sel,
  input logic [2:0]       clk_sel,
  input logic [1:0]       out_mode,
  input logic [1:0]       flag_clr,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cmp_act,
  input logic             wave_o,
  input logic             match_flag_o,
  input logic             ovf_flag_o,
  input logic             tick
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (cnt_o == '0 && !wave_o && !match_flag_o && !ovf_flag_o);
    end
  end

  a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel == 3'd0 |=> $stable(cnt_o));

  a_r3_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd2 && tick && cnt_o == cmp_act) |=> cnt_o == '0);

  a_r4_wrap_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_o == MAXV) |=> cnt_o == '0);

  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd2 && out_mode == 2'd1 && tick && cnt_o == cmp_act)
      |=> wave_o != $past(wave_o));

  a_r7_pwm_set_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd3 && out_mode == 2'd2 && tick && cnt_o == MAXV) |=> wave_o);

  a_r7_pwm_inv_clear_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd3 && out_mode == 2'd3 && tick && cnt_o == MAXV) |=> !wave_o);

  a_r8_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 3'd3 || mode_sel == 3'd7) && !tick) |=> $stable(cmp_act));

  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_o == MAXV) |=> ovf_flag_o);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_o == cmp_act && flag_clr[0]) |=> match_flag_o);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && cnt_o == cmp_act) && flag_clr[0]) |=> !match_flag_o);

  a_r11_wave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd6}) |=> $stable(wave_o));

endmodule

bind tmr8_timer tmr8_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_sel     (mode_sel),
  .clk_sel      (clk_sel),
  .out_mode     (out_mode),
  .flag_clr     (flag_clr),
  .cnt_o        (cnt_o),
  .cmp_act      (cmp_act),
  .wave_o       (wave_o),
  .match_flag_o (match_flag_o),
  .ovf_flag_o   (ovf_flag_o),
  .tick         (tick)
);

// File: tb/tmr8_timer_bench.sv
`timescale 1ns/1ps
module tmr8_timer_bench;

  logic       clk;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic [2:0] clk_sel;
  logic [1:0] out_mode;
  logic       cmp_wr_en;
  logic [7:0] cmp_wr_data;
  logic [1:0] flag_clr;
  logic [7:0] cnt_o;
  logic       wave_o, match_flag_o, ovf_flag_o;

  int checks = 0;
  int errors = 0;
  bit sb_on  = 0;
  bit done   = 0;

  tmr8_timer u_tmr8_timer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .clk_sel(clk_sel),
    .out_mode(out_mode), .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .flag_clr(flag_clr), .cnt_o(cnt_o), .wave_o(wave_o),
    .match_flag_o(match_flag_o), .ovf_flag_o(ovf_flag_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // ---------------- reference model ----------------
  function automatic bit tick_of(input logic [2:0] s, input logic [9:0] d);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return d[2:0] == 3'h7;
      3'd3: return d[4:0] == 5'h1f;
      3'd4: return d[5:0] == 6'h3f;
      3'd5: return d[6:0] == 7'h7f;
      3'd6: return d[7:0] == 8'hff;
      default: return d == 10'h3ff;
    endcase
  endfunction

  logic [9:0] m_div;
  logic [7:0] m_cnt, m_act, m_shd, m_top;
  logic       m_wave, m_mf, m_of;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = '0; m_cnt = '0; m_act = '0; m_shd = '0;
      m_wave = 1'b0; m_mf = 1'b0; m_of = 1'b0;
    end else begin
      bit tk, pwm, ctc, mt, at_top, ov;
      logic [7:0] old_shd;
      tk  = tick_of(clk_sel, m_div);
      m_div = m_div + 10'd1;
      ctc = (mode_sel == 3'd2);
      pwm = (mode_sel == 3'd3) || (mode_sel == 3'd7);
      m_top = (ctc || mode_sel == 3'd7) ? m_act : 8'hff;
      mt = tk && (m_cnt == m_act);
      at_top = tk && (m_cnt == m_top);
      ov = tk && (m_cnt == 8'hff);
      if (ctc && mt) begin
        if (out_mode == 2'd1) m_wave = !m_wave;
        else if (out_mode == 2'd2) m_wave = 1'b0;
        else if (out_mode == 2'd3) m_wave = 1'b1;
      end else if (pwm && out_mode == 2'd2) begin
        if (at_top) m_wave = 1'b1; else if (mt) m_wave = 1'b0;
      end else if (pwm && out_mode == 2'd3) begin
        if (at_top) m_wave = 1'b0; else if (mt) m_wave = 1'b1;
      end
      m_mf = mt || (m_mf && !flag_clr[0]);
      m_of = ov || (m_of && !flag_clr[1]);
      if (tk) m_cnt = at_top ? 8'h00 : m_cnt + 8'd1;
      old_shd = m_shd;
      if (cmp_wr_en) m_shd = cmp_wr_data;
      if (pwm) begin
        if (at_top) m_act = old_shd;
      end else if (cmp_wr_en) m_act = cmp_wr_data;
    end
  end

  // scoreboard, sampled 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (sb_on && !done) begin
      string tc, tw;
      tc = (mode_sel == 3'd2) ? "R3 count" :
           ((mode_sel == 3'd3 || mode_sel == 3'd7) ? "R6 count" : "R11 count");
      tw = (mode_sel == 3'd2) ? "R5 wave" :
           ((mode_sel == 3'd3 || mode_sel == 3'd7) ? "R7 wave" : "R11 wave");
      check(tc, cnt_o, m_cnt);
      check(tw, wave_o, m_wave);
      check("R9 match flag", match_flag_o, m_mf);
      check("R9 overflow flag", ovf_flag_o, m_of);
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cmp(input logic [7:0] v);
    cmp_wr_en = 1'b1; cmp_wr_data = v;
    step(1);
    cmp_wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v, input int lim, input string tag);
    int n = 0;
    while (cnt_o !== v && n < lim) begin
      step(1);
      n++;
    end
    if (n >= lim) check(tag, cnt_o, v);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] c0, mx;
    int hi;
    logic prev;
    void'($urandom(32'd2024));
    rst_n = 1'b0; mode_sel = 3'd0; clk_sel = 3'd0; out_mode = 2'd0;
    cmp_wr_en = 1'b0; cmp_wr_data = 8'd0; flag_clr = 2'd0;
    step(3);
    // R1: reset values
    check("R1 cnt in reset", cnt_o, 0);
    check("R1 wave in reset", wave_o, 0);
    check("R1 flags in reset", {match_flag_o, ovf_flag_o}, 0);
    rst_n = 1'b1;
    sb_on = 1;
    step(2);
    check("R1 cnt after reset", cnt_o, 0);

    // R2: stopped
    step(40);
    check("R2 stopped count", cnt_o, 0);

    // R2: divide by 8 and 32
    clk_sel = 3'd2; step(1); c0 = cnt_o; step(80);
    check("R2 divide-by-8 rate", cnt_o - c0, 10);
    clk_sel = 3'd3; step(1); c0 = cnt_o; step(320);
    check("R2 divide-by-32 rate", cnt_o - c0, 10);

    // R5: toggle at clk/2
    mode_sel = 3'd2; clk_sel = 3'd1; out_mode = 2'd1;
    write_cmp(8'd0);
    wait_cnt(8'd0, 300, "R5 reach zero");
    step(2);
    for (int i = 0; i < 8; i++) begin
      prev = wave_o;
      step(1);
      check("R5 toggle every clock", wave_o, !prev);
    end

    // R4: write below count misses match
    out_mode = 2'd0;
    write_cmp(8'd100);
    wait_cnt(8'd50, 300, "R4 reach 50");
    write_cmp(8'd20);
    mx = cnt_o;
    for (int i = 0; i < 300 && cnt_o != 8'd0; i++) begin
      step(1);
      if (cnt_o > mx) mx = cnt_o;
    end
    check("R4 passes through 0xFF", mx, 255);
    wait_cnt(8'd20, 300, "R3 reach compare");
    step(1);
    check("R3 clears after match", cnt_o, 0);

    // R6/R7: fixed-top PWM duty
    mode_sel = 3'd3; out_mode = 2'd2;
    write_cmp(8'd63);
    wait_cnt(8'hff, 600, "R6 reach top");
    wait_cnt(8'h00, 600, "R6 reach bottom");
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (wave_o) hi++;
      step(1);
    end
    check("R7 non-inverting high time", hi, 64);
    out_mode = 2'd3;
    wait_cnt(8'hff, 600, "R6 reach top");
    wait_cnt(8'h00, 600, "R6 reach bottom");
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (wave_o) hi++;
      step(1);
    end
    check("R7 inverting high time", hi, 192);

    // R8: buffered compare with variable top
    mode_sel = 3'd2; out_mode = 2'd0;
    write_cmp(8'd40);
    mode_sel = 3'd7;
    wait_cnt(8'd5, 600, "R8 reach 5");
    write_cmp(8'd200);
    wait_cnt(8'd40, 600, "R8 reach old top");
    step(1);
    check("R8 old top still active", cnt_o, 0);
    wait_cnt(8'd200, 600, "R8 reach new top");
    step(1);
    check("R6 new top from compare", cnt_o, 0);

    // R9/R10: flags
    mode_sel = 3'd0;
    write_cmp(8'd10);
    wait_cnt(8'd5, 600, "R10 reach 5");
    flag_clr = 2'b11; step(1); flag_clr = 2'b00;
    check("R10 both cleared", {match_flag_o, ovf_flag_o}, 0);
    wait_cnt(8'd10, 600, "R10 reach compare");
    flag_clr = 2'b01; step(1); flag_clr = 2'b00;
    check("R10 set wins over clear", match_flag_o, 1);
    flag_clr = 2'b01; step(1); flag_clr = 2'b00;
    check("R10 match flag cleared", match_flag_o, 0);
    wait_cnt(8'hff, 600, "R9 reach max");
    step(1);
    check("R9 overflow flag set", ovf_flag_o, 1);
    check("R11 wrap to zero", cnt_o, 0);

    // R11: unimplemented mode holds wave
    mode_sel = 3'd2; out_mode = 2'd1;
    write_cmp(8'd3);
    step(9);
    mode_sel = 3'd6;
    step(1);
    prev = wave_o;
    for (int i = 0; i < 300; i++) begin
      step(1);
      if (wave_o != prev) check("R11 wave held", wave_o, prev);
    end
    check("R11 wave held at end", wave_o, prev);

    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      int r;
      bit ctcseg;
      r = $urandom % 4;
      mode_sel = (r == 0) ? 3'd2 : (r == 1) ? 3'd3 : (r == 2) ? 3'd7 : 3'($urandom % 8);
      r = $urandom % 4;
      clk_sel = (r < 2) ? 3'd1 : (r == 2) ? 3'd2 : 3'($urandom % 8);
      out_mode = 2'($urandom % 4);
      ctcseg = (mode_sel == 3'd2) || (mode_sel == 3'd7);
      for (int c = 0; c < 300; c++) begin
        cmp_wr_en   = (($urandom % 20) == 0);
        cmp_wr_data = ctcseg ? 8'($urandom % 64) : 8'($urandom);
        flag_clr    = (($urandom % 10) == 0) ? 2'($urandom % 4) : 2'b00;
        step(1);
      end
      cmp_wr_en = 1'b0; flag_clr = 2'b00;
    end

    step(2);
    done = 1;
    summary();
    $finish;
  end

endmodule